// File: doc/BRIEF.md
# Transparent Transmit Descriptor Engine

This engine walks a ring of transmit buffer descriptors kept in a local memory. It turns the data each descriptor points at into a continuous stream of transparent serial characters. Each descriptor takes 8 bytes. The engine reads the control word, the octet count and the buffer address. It then fetches the buffer contents through a single request/acknowledge memory port and shifts each character out least-significant bit first, one bit per pulse of the bit clock enable. When a buffer has been handed to the serializer, the engine writes a fresh control word back into the descriptor. If the descriptor asks for it, the engine also raises a one-cycle event.

Buffers chain without a gap unless a buffer ends a frame. After the end of a frame, after an underrun and after reset, the engine waits for a pulse on the synchronization input before it reads the next descriptor. A continuous-mode descriptor stays ready, so the ring sends it again. When the engine meets a descriptor that is not ready, it re-reads that descriptor at a fixed interval and keeps the line idle.

Top module: `tdesc_tx_engine`

## Requirements
- R1: Descriptor i sits at ring base + 8*i (the base is a multiple of 8). The control word is at +0, the octet count at +2 and the buffer address at +4, each a 16-bit little-endian halfword. The control bits are ready = bit 0, wrap = bit 2, interrupt = bit 3, frame end = bit 4, continuous = bit 6 and underrun = bit 14. The word written back keeps wrap, interrupt, frame end and continuous, and writes every other bit except ready and underrun as zero.
- R2: The line `tx_d` changes only at a clock edge where `bit_en` is high. At each such edge it takes the next character bit, least-significant bit first. When no character is pending it takes the idle level 1. After reset the line is 1.
- R3: When the interrupt bit is set, the cycle after the writeback is acknowledged carries a one-cycle `ev_txb` pulse, or an `ev_txe` pulse if the buffer ended in underrun. When the interrupt bit is clear, neither event is raised. The two events never occur together.
- R4: When frame end is clear and the next descriptor is ready, its first character follows the last character of the current buffer with no idle bit in between.
- R5: After reset, after a buffer with frame end set and after an underrun, no descriptor is read until `tx_sync` is pulsed.
- R6: At close, ready stays set when continuous is set and no error occurred. Otherwise ready is cleared.
- R7: An underrun occurs when the current character has finished and the next character of the buffer has not yet been fetched at a `bit_en` edge. On underrun the line goes idle, the rest of the buffer is dropped, the written-back word has underrun set and ready clear whatever continuous is, and the engine then waits for synchronization.
- R8: The engine writes only the control word. The octet count and the buffer address are never modified.
- R9: The character length `cfg_char_len` runs from 4 to 16; values outside that range are clamped. Characters of 8 bits or fewer take one byte each: an even address selects the low byte of the halfword and an odd address selects the high byte. Wider characters take one halfword each, with an even address and an even count. Bits above the character length are not sent.
- R10: After the descriptor with wrap set, the next descriptor read is the one at the ring base. Otherwise the next descriptor read is at +8.
- R11: A descriptor read with ready clear is read again every POLL_CYC+1 cycles, and the line stays idle meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | AW | Byte address of the first descriptor |
| cfg_char_len | input | 5 | Character length in bits |
| tx_sync | input | 1 | Synchronization pulse that starts a frame |
| bit_en | input | 1 | Serial bit clock enable |
| tx_d | output | 1 | Serial data line |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Byte address; halfword access ignores bit 0 |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid in this cycle |
| mem_rdata | input | 16 | Read halfword |
| ev_txb | output | 1 | Buffer sent event |
| ev_txe | output | 1 | Buffer error event |

## Verification
Two jobs fall in the same cycle here. The first is closing a buffer: its writeback and its event. The second is serializing that buffer's last characters, while the first character of the next buffer is fetched into the holding register. The bench provokes this by chaining two descriptors with frame end clear, so the close, the next descriptor read and the first fetch all happen while bits are still leaving the shifter. A bit-level model compares the line on every clock, so a single idle bit at the seam is caught. The written-back words and the event counts are then checked against the descriptor bits.

// File: rtl/tdesc_tx_pkg.sv
package tdesc_tx_pkg;

    localparam int CLW    = 5;
    localparam int MIN_CL = 4;
    localparam int MAX_CL = 16;

    localparam int F_RDY  = 0;
    localparam int F_WRAP = 2;
    localparam int F_INT  = 3;
    localparam int F_LAST = 4;
    localparam int F_CONT = 6;
    localparam int F_UNDR = 14;

    typedef enum logic [2:0] {
        SQ_WAIT_SYNC,
        SQ_RD_CTL,
        SQ_POLL,
        SQ_RD_LEN,
        SQ_RD_PTR,
        SQ_FETCH,
        SQ_CLOSE
    } seq_state_e;

    typedef struct packed {
        logic under;
        logic cont;
        logic last;
        logic intr;
        logic wrap;
        logic rdy;
    } bd_ctl_t;

    function automatic bd_ctl_t ctl_from_word(input logic [15:0] w);
        bd_ctl_t c;
        c.under = w[F_UNDR];
        c.cont  = w[F_CONT];
        c.last  = w[F_LAST];
        c.intr  = w[F_INT];
        c.wrap  = w[F_WRAP];
        c.rdy   = w[F_RDY];
        return c;
    endfunction

    function automatic logic [15:0] ctl_to_word(input bd_ctl_t c);
        logic [15:0] w;
        w         = '0;
        w[F_UNDR] = c.under;
        w[F_CONT] = c.cont;
        w[F_LAST] = c.last;
        w[F_INT]  = c.intr;
        w[F_WRAP] = c.wrap;
        w[F_RDY]  = c.rdy;
        return w;
    endfunction

    function automatic logic [CLW-1:0] clamp_len(input logic [CLW-1:0] v);
        if (v < CLW'(MIN_CL)) return CLW'(MIN_CL);
        if (v > CLW'(MAX_CL)) return CLW'(MAX_CL);
        return v;
    endfunction

endpackage

// File: rtl/tdesc_tx_serializer.sv
module tdesc_tx_serializer
    import tdesc_tx_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           bit_en,
    input  logic [CLW-1:0] char_len,
    input  logic           push,
    input  logic [15:0]    push_data,
    input  logic           live,
    output logic           full,
    output logic           urun,
    output logic           tx_d
);

    logic [15:0]    hold_q;
    logic [15:0]    sh_q;
    logic [CLW-1:0] cnt_q;
    logic           full_q;
    logic           txd_q;

    assign full = full_q;
    assign tx_d = txd_q;
    assign urun = bit_en && (cnt_q == '0) && !full_q && live;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            sh_q   <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
            txd_q  <= 1'b1;
        end else begin
            if (push) begin
                hold_q <= push_data;
                full_q <= 1'b1;
            end
            if (bit_en) begin
                if (cnt_q != '0) begin
                    txd_q <= sh_q[0];
                    sh_q  <= sh_q >> 1;
                    cnt_q <= cnt_q - 1'b1;
                end else if (full_q) begin
                    txd_q  <= hold_q[0];
                    sh_q   <= hold_q >> 1;
                    cnt_q  <= char_len - 1'b1;
                    full_q <= 1'b0;
                end else begin
                    txd_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tdesc_tx_sequencer.sv
module tdesc_tx_sequencer
    import tdesc_tx_pkg::*;
#(
    parameter int AW       = 16,
    parameter int POLL_CYC = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ring_base,
    input  logic          wide,
    input  logic          tx_sync,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [15:0]   mem_rdata,
    input  logic          full,
    input  logic          urun,
    output logic          push,
    output logic [15:0]   push_data,
    output logic          live,
    output logic          ev_txb,
    output logic          ev_txe
);

    localparam int PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam logic [AW-1:0] BD_STRIDE = AW'(8);

    seq_state_e    st_q;
    logic [AW-1:0] bd_q;
    logic [AW-1:0] ptr_q;
    logic [15:0]   rem_q;
    bd_ctl_t       ctl_q;
    bd_ctl_t       wb_ctl;
    logic          err_q;
    logic [PW-1:0] poll_q;
    logic [15:0]   step;

    assign step = wide ? 16'd2 : 16'd1;
    assign live = (st_q == SQ_FETCH);

    always_comb begin
        wb_ctl       = ctl_q;
        wb_ctl.rdy   = ctl_q.cont && !err_q;
        wb_ctl.under = err_q;
    end

    always_comb begin
        push_data = wide ? mem_rdata
                         : {8'h00, (ptr_q[0] ? mem_rdata[15:8] : mem_rdata[7:0])};
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = bd_q;
        mem_wdata = '0;
        push      = 1'b0;
        case (st_q)
            SQ_RD_CTL: mem_req = 1'b1;
            SQ_RD_LEN: begin
                mem_req  = 1'b1;
                mem_addr = bd_q + AW'(2);
            end
            SQ_RD_PTR: begin
                mem_req  = 1'b1;
                mem_addr = bd_q + AW'(4);
            end
            SQ_FETCH: begin
                if (!urun && !full) begin
                    mem_req  = 1'b1;
                    mem_addr = ptr_q;
                    push     = mem_ack;
                end
            end
            SQ_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = ctl_to_word(wb_ctl);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_WAIT_SYNC;
            bd_q   <= ring_base;
            ptr_q  <= '0;
            rem_q  <= '0;
            ctl_q  <= '0;
            err_q  <= 1'b0;
            poll_q <= '0;
            ev_txb <= 1'b0;
            ev_txe <= 1'b0;
        end else begin
            ev_txb <= 1'b0;
            ev_txe <= 1'b0;
            case (st_q)
                SQ_WAIT_SYNC: if (tx_sync) st_q <= SQ_RD_CTL;
                SQ_RD_CTL: if (mem_ack) begin
                    ctl_q <= ctl_from_word(mem_rdata);
                    if (mem_rdata[F_RDY]) begin
                        st_q <= SQ_RD_LEN;
                    end else begin
                        poll_q <= PW'(POLL_CYC - 1);
                        st_q   <= SQ_POLL;
                    end
                end
                SQ_POLL: begin
                    if (poll_q == '0) st_q <= SQ_RD_CTL;
                    else poll_q <= poll_q - 1'b1;
                end
                SQ_RD_LEN: if (mem_ack) begin
                    rem_q <= mem_rdata;
                    st_q  <= SQ_RD_PTR;
                end
                SQ_RD_PTR: if (mem_ack) begin
                    ptr_q <= AW'(mem_rdata);
                    err_q <= 1'b0;
                    st_q  <= (rem_q == '0) ? SQ_CLOSE : SQ_FETCH;
                end
                SQ_FETCH: begin
                    if (urun) begin
                        err_q <= 1'b1;
                        st_q  <= SQ_CLOSE;
                    end else if (push) begin
                        ptr_q <= ptr_q + AW'(step);
                        if (rem_q <= step) st_q <= SQ_CLOSE;
                        else rem_q <= rem_q - step;
                    end
                end
                SQ_CLOSE: if (mem_ack) begin
                    ev_txb <= ctl_q.intr && !err_q;
                    ev_txe <= ctl_q.intr && err_q;
                    bd_q   <= ctl_q.wrap ? ring_base : bd_q + BD_STRIDE;
                    st_q   <= (ctl_q.last || err_q) ? SQ_WAIT_SYNC : SQ_RD_CTL;
                end
                default: st_q <= SQ_WAIT_SYNC;
            endcase
        end
    end

endmodule

// File: rtl/tdesc_tx_engine.sv
module tdesc_tx_engine
    import tdesc_tx_pkg::*;
#(
    parameter int AW       = 16,
    parameter int POLL_CYC = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_ring_base,
    input  logic [4:0]    cfg_char_len,
    input  logic          tx_sync,
    input  logic          bit_en,
    output logic          tx_d,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [15:0]   mem_rdata,
    output logic          ev_txb,
    output logic          ev_txe
);

    logic [CLW-1:0] clen;
    logic           wide;
    logic           push;
    logic [15:0]    push_data;
    logic           live;
    logic           full;
    logic           urun;

    assign clen = clamp_len(cfg_char_len);
    assign wide = clen > CLW'(8);

    tdesc_tx_sequencer #(
        .AW       (AW),
        .POLL_CYC (POLL_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ring_base (cfg_ring_base),
        .wide      (wide),
        .tx_sync   (tx_sync),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .full      (full),
        .urun      (urun),
        .push      (push),
        .push_data (push_data),
        .live      (live),
        .ev_txb    (ev_txb),
        .ev_txe    (ev_txe)
    );

    tdesc_tx_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .char_len  (clen),
        .push      (push),
        .push_data (push_data),
        .live      (live),
        .full      (full),
        .urun      (urun),
        .tx_d      (tx_d)
    );

endmodule

// File: rtl/tdesc_tx_engine_chk.sv
module tdesc_tx_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        bit_en,
    input logic        tx_d,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [2:0]  mem_addr_lo,
    input logic [15:0] mem_wdata,
    input logic        ev_txb,
    input logic        ev_txe
);

    AST_EV_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ev_txb && ev_txe)); // R3

    AST_EV_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        (ev_txb || ev_txe) |-> $past(mem_req && mem_we && mem_ack)); // R3

    AST_WB_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ((mem_wdata & ~16'h405D) == 16'h0000)); // R1

    AST_WB_UN_DROPS_R: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_wdata[14]) |-> !mem_wdata[0]); // R7

    AST_WB_CTL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr_lo == 3'b000)); // R8

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_d)); // R2

endmodule

bind tdesc_tx_engine tdesc_tx_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .tx_d        (tx_d),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr_lo (mem_addr[2:0]),
    .mem_wdata   (mem_wdata),
    .ev_txb      (ev_txb),
    .ev_txe      (ev_txe)
);

// File: tb/tdesc_tx_engine_bench.sv
`timescale 1ns/1ps
module tdesc_tx_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_ring_base = 16'h0000;
    logic [4:0]  cfg_char_len = 5'd8;
    logic        tx_sync = 1'b0;
    logic        bit_en = 1'b0;
    logic        tx_d;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        ev_txb, ev_txe;

    logic [15:0] ram [0:255];
    logic        stall = 1'b0;
    int          n_chk = 0, n_err = 0, n_txb = 0, n_txe = 0, n_ctl_rd = 0;
    bit          done = 1'b0;
    bit          exp_q[$];
    logic        m_txd = 1'b1;

    always #4 clk = ~clk;

    assign mem_ack   = mem_req && !stall;
    assign mem_rdata = ram[mem_addr[8:1]];

    tdesc_tx_engine u_tdesc_tx_engine (
        .clk(clk), .rst(rst), .cfg_ring_base(cfg_ring_base),
        .cfg_char_len(cfg_char_len), .tx_sync(tx_sync), .bit_en(bit_en),
        .tx_d(tx_d), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ev_txb(ev_txb), .ev_txe(ev_txe)
    );

    // memory and reference model of the serial line
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack) ram[mem_addr[8:1]] <= mem_wdata;
        if (rst) begin
            m_txd <= 1'b1;
        end else begin
            if (ev_txb) n_txb++;
            if (ev_txe) n_txe++;
            if (mem_req && !mem_we && mem_ack && mem_addr == 16'h0000) n_ctl_rd++;
            if (bit_en) m_txd <= (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
        end
    end

    // R2 R4: line compared with the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_chk++;
            if (tx_d !== m_txd) begin
                n_err++;
                $display("FAIL R2/R4 line at %0t: got %b expected %b", $time, tx_d, m_txd);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bits(input int n);
        repeat (n) begin
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
            repeat (15) @(negedge clk);
        end
    endtask

    task automatic sync_pulse();
        tx_sync = 1'b1;
        @(negedge clk);
        tx_sync = 1'b0;
    endtask

    task automatic set_bd(input int idx, input logic [15:0] c, input logic [15:0] l,
                          input logic [15:0] p);
        ram[idx*4]     = c;
        ram[idx*4 + 1] = l;
        ram[idx*4 + 2] = p;
    endtask

    task automatic set_byte(input int a, input logic [7:0] b);
        if (a % 2 == 1) ram[a/2][15:8] = b;
        else            ram[a/2][7:0]  = b;
    endtask

    task automatic exp_char(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v[i]);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
        tick(5);
        rst = 1'b0;
        tick(1);
        chk("R2 reset line idle", 32'(tx_d), 32'h1);
        chk("R5 reset no request", 32'(mem_req), 32'h0);

        // chained buffers, odd pointer, reserved bits, wrap
        set_bd(0, 16'h800B, 16'd2, 16'h0081);
        set_bd(1, 16'h001D, 16'd1, 16'h0090);
        set_byte(16'h81, 8'h3C); set_byte(16'h82, 8'hA7); set_byte(16'h90, 8'h5E);
        tick(10);
        chk("R5 no read before sync", 32'(n_ctl_rd), 32'h0);
        exp_char(16'h3C, 8); exp_char(16'hA7, 8); exp_char(16'h5E, 8);
        sync_pulse(); tick(20); bits(28); tick(20);
        chk("R1 R6 writeback bd0", 32'(ram[0]), 32'h0008);
        chk("R1 writeback bd1", 32'(ram[4]), 32'h001C);
        chk("R8 length kept", 32'(ram[1]), 32'd2);
        chk("R8 pointer kept", 32'(ram[6]), 32'h0090);
        chk("R3 two txb events", 32'(n_txb), 32'd2);
        chk("R4 all bits sent", 32'(exp_q.size()), 32'd0);

        // wrap returns to bd0; continuous keeps ready; frame end waits
        set_bd(0, 16'h0055, 16'd1, 16'h00A0);
        set_byte(16'hA0, 8'h96);
        exp_char(16'h96, 8);
        sync_pulse(); tick(20); bits(16); tick(10);
        chk("R10 wrap to base sent bd0", 32'(exp_q.size()), 32'd0);
        chk("R6 continuous keeps ready", 32'(ram[0]), 32'h0055);
        chk("R3 no event without interrupt bit", 32'(n_txb + n_txe), 32'd2);
        exp_char(16'h96, 8);
        sync_pulse(); tick(20); bits(8); tick(10);
        chk("R6 buffer resent", 32'(exp_q.size()), 32'd0);

        // underrun with continuous set
        set_bd(0, 16'h005D, 16'd3, 16'h00B0);
        set_byte(16'hB0, 8'hC3); set_byte(16'hB1, 8'h11); set_byte(16'hB2, 8'h22);
        exp_char(16'hC3, 8);
        sync_pulse(); tick(20);
        stall = 1'b1; bits(12); stall = 1'b0; tick(20);
        chk("R7 underrun word", 32'(ram[0]), 32'h405C);
        chk("R7 R3 txe event", 32'(n_txe), 32'd1);
        chk("R7 no txb on error", 32'(n_txb), 32'd2);
        chk("R7 frame stopped", 32'(exp_q.size()), 32'd0);

        // 12-bit characters in halfwords, top bits ignored
        cfg_char_len = 5'd12;
        set_bd(0, 16'h001D, 16'd4, 16'h00C0);
        ram[16'h60] = 16'hF123; ram[16'h61] = 16'hEABC;
        exp_char(16'h0123, 12); exp_char(16'h0ABC, 12);
        sync_pulse(); tick(20); bits(28); tick(20);
        chk("R9 wide chars sent", 32'(exp_q.size()), 32'd0);
        chk("R9 wide writeback", 32'(ram[0]), 32'h001C);
        chk("R3 txb after wide", 32'(n_txb), 32'd3);

        // 5-bit characters from bytes, odd start
        cfg_char_len = 5'd5;
        set_bd(0, 16'h0015, 16'd2, 16'h00D1);
        set_byte(16'hD1, 8'hE7); set_byte(16'hD2, 8'h3A);
        exp_char(16'h0007, 5); exp_char(16'h001A, 5);
        sync_pulse(); tick(20); bits(14); tick(20);
        chk("R9 short chars sent", 32'(exp_q.size()), 32'd0);
        chk("R9 short writeback", 32'(ram[0]), 32'h0014);

        // polling a descriptor that is not ready
        set_bd(0, 16'h0000, 16'd1, 16'h00D1);
        n_ctl_rd = 0;
        sync_pulse(); tick(100);
        chk("R11 poll reads >= 3", 32'(n_ctl_rd >= 3), 32'h1);
        chk("R11 poll reads <= 4", 32'(n_ctl_rd <= 4), 32'h1);
        ram[0] = 16'h0015;
        exp_char(16'h0007, 5);
        tick(50); bits(6); tick(10);
        chk("R11 sent after ready", 32'(exp_q.size()), 32'd0);
        chk("R11 writeback", 32'(ram[0]), 32'h0014);
        chk("R3 total events", 32'(n_txb + n_txe), 32'd4);

        tick(5);
        finish_up();
    end

endmodule